// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block is the second decoding stage that picks the operation of a 32-bit integer ALU in a single-cycle processor. The main controller looks only at the opcode and emits a 2-bit operation class. This decoder takes that class together with the 6-bit function code of the instruction and produces the 3-bit operation select that goes straight to the ALU.

Two of the classes fix the operation outright. Address generation for loads and stores always adds. The equality branch compare always subtracts. A third class marks a register-format instruction, and the function code then chooses between add, subtract, and, or and set-on-less-than. A function code that is not recognised, and the fourth class, which is reserved, both fall back to add and raise an illegal-operation flag so that the surrounding control can trap.

The block is purely combinational: it has no clock, no state and no handshake. Both outputs follow the inputs within the same cycle.

Top module: `alu_op_decoder`

## Requirements
- R1: With op_class = 00 (memory), alu_sel is 010 (add) for every one of the 64 fn_code values.
- R2: With op_class = 01 (branch compare), alu_sel is 110 (subtract) for every one of the 64 fn_code values.
- R3: With op_class = 10 (register format) and fn_code = 100000, alu_sel is 010 (add).
- R4: With op_class = 10 and fn_code = 100010, alu_sel is 110 (subtract).
- R5: With op_class = 10, fn_code = 100100 gives alu_sel 000 (and) and fn_code = 100101 gives alu_sel 001 (or).
- R6: With op_class = 10 and fn_code = 101010, alu_sel is 111 (set on less than).
- R7: With op_class = 10 and any fn_code other than the five listed in R3 to R6, alu_sel is 010 and illegal_op is 1.
- R8: With op_class = 11 (reserved), alu_sel is 010 and illegal_op is 1 for every fn_code.
- R9: illegal_op is 0 for op_class 00 and 01 whatever fn_code holds, and for op_class 10 with any of the five recognised fn_code values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from the main controller: 00 memory, 01 branch compare, 10 register format, 11 reserved |
| fn_code | input | 6 | Function code field of the instruction |
| alu_sel | output | 3 | ALU operation select: 000 and, 001 or, 010 add, 110 subtract, 111 set on less than |
| illegal_op | output | 1 | High when the class is reserved or a register-format function code is not recognised |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same cycle as the input that triggers it, and never later. A wrong entry in the function-code table shows only under the register-format class, as a wrong select or as a flag raised on a recognised code. A leak of the function code into the fixed classes shows as an alu_sel other than add or subtract under classes 00 and 01, which is why every fixed class is driven with all 64 function codes.

// File: rtl/aluop_pkg.sv
package aluop_pkg;

  localparam int CLASS_W = 2;
  localparam int FN_W    = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_REG = 2'b10,
    CLS_RSV = 2'b11
  } op_class_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alu_sel_e;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic     known;
    alu_sel_e sel;
  } fn_dec_t;

endpackage

// File: rtl/aluop_fn_decode.sv
module aluop_fn_decode
  import aluop_pkg::*;
(
  input  logic [FN_W-1:0] fn_code,
  output fn_dec_t         fn_dec
);

  always_comb begin
    fn_dec.known = 1'b1;
    unique case (fn_code)
      FN_ADD:  fn_dec.sel = SEL_ADD;
      FN_SUB:  fn_dec.sel = SEL_SUB;
      FN_AND:  fn_dec.sel = SEL_AND;
      FN_OR:   fn_dec.sel = SEL_OR;
      FN_SLT:  fn_dec.sel = SEL_SLT;
      default: begin
        fn_dec.known = 1'b0;
        fn_dec.sel   = SEL_ADD;
      end
    endcase
  end

  // R7: an unknown code must offer the safe default to the next level
  always_comb begin
    if (!$isunknown(fn_code)) begin
      p_unknown_is_add_r7: assert (fn_dec.known || fn_dec.sel == SEL_ADD)
        else $error("unknown function code did not map to add");
    end
  end

endmodule

// File: rtl/aluop_class_select.sv
module aluop_class_select
  import aluop_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  input  fn_dec_t            fn_dec,
  output logic [SEL_W-1:0]   sel,
  output logic               illegal
);

  always_comb begin
    illegal = 1'b0;
    unique case (op_class_e'(op_class))
      CLS_MEM: sel = SEL_ADD;
      CLS_BR:  sel = SEL_SUB;
      CLS_REG: begin
        sel     = fn_dec.sel;
        illegal = !fn_dec.known;
      end
      default: begin
        sel     = SEL_ADD;
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import aluop_pkg::*;
(
  input  logic [1:0] op_class,
  input  logic [5:0] fn_code,
  output logic [2:0] alu_sel,
  output logic       illegal_op
);

  fn_dec_t fn_dec;

  aluop_fn_decode u_fn (
    .fn_code (fn_code),
    .fn_dec  (fn_dec)
  );

  aluop_class_select u_cls (
    .op_class (op_class),
    .fn_dec   (fn_dec),
    .sel      (alu_sel),
    .illegal  (illegal_op)
  );

  always_comb begin
    if (!$isunknown({op_class, fn_code})) begin
      p_mem_add_r1: assert (op_class != 2'b00 || alu_sel == 3'b010)
        else $error("memory class not add");
      p_branch_sub_r2: assert (op_class != 2'b01 || alu_sel == 3'b110)
        else $error("branch class not subtract");
      p_reserved_flag_r8: assert (op_class != 2'b11 || (illegal_op && alu_sel == 3'b010))
        else $error("reserved class not flagged");
      p_fixed_legal_r9: assert (op_class[1] || !illegal_op)
        else $error("fixed class flagged illegal");
      p_flag_default_r7: assert (!illegal_op || alu_sel == 3'b010)
        else $error("illegal operation without add default");
    end
  end

endmodule

// File: tb/test_alu_op_decoder.sv
module test_alu_op_decoder;

  logic       clk = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [5:0] fn_code  = 6'b000000;
  logic [2:0] alu_sel;
  logic       illegal_op;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  alu_op_decoder i_alu_op_decoder (
    .op_class   (op_class),
    .fn_code    (fn_code),
    .alu_sel    (alu_sel),
    .illegal_op (illegal_op)
  );

  task automatic apply(input logic [1:0] c, input logic [5:0] f);
    @(negedge clk);
    op_class = c;
    fn_code  = f;
    #1;
  endtask

  task automatic check(input string req, input logic [2:0] exp_sel, input logic exp_ill);
    n_checks++;
    if (alu_sel !== exp_sel || illegal_op !== exp_ill) begin
      n_fail++;
      $display("FAIL %s: class=%b fn=%b got sel=%b ill=%b expected sel=%b ill=%b",
               req, op_class, fn_code, alu_sel, illegal_op, exp_sel, exp_ill);
    end
  endtask

  function automatic bit is_known(input logic [5:0] f);
    return f == 6'b100000 || f == 6'b100010 || f == 6'b100100 ||
           f == 6'b100101 || f == 6'b101010;
  endfunction

  task automatic t_idle;
    apply(2'b00, 6'b000000);
    check("R1 idle inputs", 3'b010, 1'b0);
  endtask

  task automatic t_mem_class;
    for (int f = 0; f < 64; f++) begin
      apply(2'b00, 6'(f));
      check("R1/R9 memory class", 3'b010, 1'b0);
    end
  endtask

  task automatic t_branch_class;
    for (int f = 0; f < 64; f++) begin
      apply(2'b01, 6'(f));
      check("R2/R9 branch class", 3'b110, 1'b0);
    end
  endtask

  task automatic t_reg_known;
    apply(2'b10, 6'b100000); check("R3 add", 3'b010, 1'b0);
    apply(2'b10, 6'b100010); check("R4 sub", 3'b110, 1'b0);
    apply(2'b10, 6'b100100); check("R5 and", 3'b000, 1'b0);
    apply(2'b10, 6'b100101); check("R5 or",  3'b001, 1'b0);
    apply(2'b10, 6'b101010); check("R6 slt", 3'b111, 1'b0);
    apply(2'b10, 6'b100100); check("R5 and after slt", 3'b000, 1'b0);
  endtask

  task automatic t_reg_unknown;
    for (int f = 0; f < 64; f++) begin
      if (!is_known(6'(f))) begin
        apply(2'b10, 6'(f));
        check("R7 unknown code", 3'b010, 1'b1);
      end
    end
  endtask

  task automatic t_reserved_class;
    for (int f = 0; f < 64; f++) begin
      apply(2'b11, 6'(f));
      check("R8 reserved class", 3'b010, 1'b1);
    end
  endtask

  task automatic t_class_switch;
    apply(2'b10, 6'b101010); check("R6 slt before switch", 3'b111, 1'b0);
    apply(2'b01, 6'b101010); check("R2 same code branch", 3'b110, 1'b0);
    apply(2'b00, 6'b100100); check("R1 and code ignored", 3'b010, 1'b0);
    apply(2'b10, 6'b111111); check("R7 all ones", 3'b010, 1'b1);
    apply(2'b01, 6'b111111); check("R9 flag drops", 3'b110, 1'b0);
  endtask

  initial begin
    t_idle();
    t_mem_class();
    t_branch_class();
    t_reg_known();
    t_reg_unknown();
    t_reserved_class();
    t_class_switch();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got done=0 expected done=1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule